// File: doc/BRIEF.md
# Hot-Swap Bus Segment Join Controller

This block decides when the two halves of a two-wire serial bus, an input side and an output side, may be joined through the pass logic. It samples digital copies of the data and clock lines on both sides and an enable input. It drives a join signal that gates the pass-through path, a ready flag, and an enable for the output-side rise-time accelerators.

A join is made only at a safe point. Either both sides have been quiet for the idle time, or one side ends a transfer with a stop condition while the other side is quiet. While reset is held, which acts as the power-on lockout, the bus is ignored. A stuck-bus recovery sequencer can order a disconnect. After such a fault, a fresh rising edge on enable forces the join straight away and sends a restart pulse to the stuck-bus timers.

Top module: `hsw_link_ctrl`

## Requirements
- R1: While reset is high, and after it until a join rule is met, link_o, ready_o and accel_en_o are 0.
- R2: With enable high and all four lines high continuously for IDLE_CYC cycles after synchronisation, the segments are joined (link_o = 1).
- R3: A stop condition (SDA rising while SCL is high) on one side while the other side is idle joins the segments without waiting for the first side's idle time.
- R4: Raising enable while a side is busy does not join. A stop condition on one side while the other side is busy does not join.
- R5: When enable falls, link_o and ready_o go low on the third rising clock edge after the change and stay low while enable is low.
- R6: ready_o is high exactly when the segments are joined.
- R7: A fault_drop_i pulse disconnects on the next clock edge, and the segments stay apart while the bus stays busy.
- R8: A rising edge of enable after a fault forces a join even while a line is stuck low, with a single-cycle timer_restart_o pulse.
- R9: After a fault, the segments rejoin through the normal idle rule without a restart pulse once the bus frees.
- R10: accel_en_o is high only while joined and fault_busy_i is low.
- R11: If enable falls in the same cycle that a stop condition would join the segments, the segments stay apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset and power-on lockout |
| en_i | input | 1 | Join enable |
| sda_in_i | input | 1 | Data line, input side |
| scl_in_i | input | 1 | Clock line, input side |
| sda_out_i | input | 1 | Data line, output side |
| scl_out_i | input | 1 | Clock line, output side |
| fault_drop_i | input | 1 | Disconnect order from the recovery sequencer |
| fault_busy_i | input | 1 | Recovery clocking or stop generation in progress |
| link_o | output | 1 | Joins the segments through the pass logic |
| ready_o | output | 1 | Segments joined |
| accel_en_o | output | 1 | Rise-time accelerator enable |
| timer_restart_o | output | 1 | One-cycle restart for the stuck-bus timers |

## Verification
Two events can meet in one cycle: enable falling and a stop condition that would otherwise complete a join. The bench drives the enable line and the data line in the same cycle, so both pass through equal synchroniser depth and reach the decision logic together. Enable must win, and no join may appear then or later. The second pairing is a fault order arriving while a join rule is true, and the checker requires that the fault wins.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ON    = 2'd2,
    ST_FAULT = 2'd3
  } link_st_t;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hsw_side_mon.sv
module hsw_side_mon #(
  parameter int IDLE_CYC = 23750
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_s,
  input  logic scl_s,
  output logic stop_o,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYC);

  logic [CW-1:0] cnt_q;
  logic          sda_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      sda_prev_q <= 1'b1;
    end else begin
      sda_prev_q <= sda_s;
      if (!(sda_s && scl_s))
        cnt_q <= '0;
      else if (cnt_q != IDLE_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stop_o = sda_s && !sda_prev_q && scl_s;
  assign idle_o = (cnt_q == IDLE_MAX);
endmodule

// File: rtl/hsw_link_fsm.sv
module hsw_link_fsm
  import hsw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_s,
  input  logic [1:0] stop_i,
  input  logic [1:0] idle_i,
  input  logic fault_drop_i,
  input  logic fault_busy_i,
  output logic link_o,
  output logic ready_o,
  output logic accel_en_o,
  output logic restart_o
);
  link_st_t st_q, st_d;
  logic en_prev_q, flt_seen_q, force_d, join_ok, en_rise;

  assign en_rise = en_s && !en_prev_q;
  assign join_ok = (idle_i[0] && idle_i[1]) ||
                   (stop_i[0] && idle_i[1]) ||
                   (stop_i[1] && idle_i[0]);

  always_comb begin
    st_d    = st_q;
    force_d = 1'b0;
    if (!en_s) begin
      st_d = ST_OFF;
    end else if (fault_drop_i) begin
      st_d = ST_FAULT;
    end else begin
      case (st_q)
        ST_OFF: begin
          if (en_rise && flt_seen_q) begin
            st_d    = ST_ON;
            force_d = 1'b1;
          end else if (join_ok) begin
            st_d = ST_ON;
          end else begin
            st_d = ST_WAIT;
          end
        end
        ST_WAIT:  if (join_ok) st_d = ST_ON;
        ST_FAULT: if (join_ok) st_d = ST_ON;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_OFF;
      en_prev_q  <= 1'b0;
      flt_seen_q <= 1'b0;
      link_o     <= 1'b0;
      ready_o    <= 1'b0;
      accel_en_o <= 1'b0;
      restart_o  <= 1'b0;
    end else begin
      st_q       <= st_d;
      en_prev_q  <= en_s;
      if (st_d == ST_FAULT)   flt_seen_q <= 1'b1;
      else if (st_d == ST_ON) flt_seen_q <= 1'b0;
      link_o     <= (st_d == ST_ON);
      ready_o    <= (st_d == ST_ON);
      accel_en_o <= (st_d == ST_ON) && !fault_busy_i;
      restart_o  <= force_d;
    end
  end
endmodule

// File: rtl/hsw_link_ctrl.sv
module hsw_link_ctrl #(
  parameter int IDLE_CYC = 23750
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic sda_in_i,
  input  logic scl_in_i,
  input  logic sda_out_i,
  input  logic scl_out_i,
  input  logic fault_drop_i,
  input  logic fault_busy_i,
  output logic link_o,
  output logic ready_o,
  output logic accel_en_o,
  output logic timer_restart_o
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0] sda_raw, scl_raw, sda_s, scl_s, stop_v, idle_v;
  logic en_s;

  assign sda_raw = {sda_out_i, sda_in_i};
  assign scl_raw = {scl_out_i, scl_in_i};

  hsw_sync #(.W(2*NSIDE), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst(rst),
    .d_i({scl_raw, sda_raw}),
    .q_o({scl_s, sda_s})
  );

  hsw_sync #(.W(1), .RST_VAL(1'b0)) u_en_sync (
    .clk(clk), .rst(rst), .d_i(en_i), .q_o(en_s)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    hsw_side_mon #(.IDLE_CYC(IDLE_CYC)) u_mon (
      .clk(clk), .rst(rst),
      .sda_s(sda_s[g]), .scl_s(scl_s[g]),
      .stop_o(stop_v[g]), .idle_o(idle_v[g])
    );
  end

  hsw_link_fsm u_fsm (
    .clk(clk), .rst(rst), .en_s(en_s),
    .stop_i(stop_v), .idle_i(idle_v),
    .fault_drop_i(fault_drop_i), .fault_busy_i(fault_busy_i),
    .link_o(link_o), .ready_o(ready_o),
    .accel_en_o(accel_en_o), .restart_o(timer_restart_o)
  );
endmodule

// File: rtl/hsw_link_ctrl_chk.sv
module hsw_link_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic fault_drop_i,
  input logic link_o,
  input logic ready_o,
  input logic accel_en_o,
  input logic timer_restart_o
);
  // R10
  accel_only_linked_chk: assert property (@(posedge clk) disable iff (rst)
    accel_en_o |-> link_o);

  // R6
  ready_tracks_link_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o == link_o);

  // R7
  fault_breaks_link_chk: assert property (@(posedge clk) disable iff (rst)
    fault_drop_i |=> !link_o);

  // R8
  restart_with_link_chk: assert property (@(posedge clk) disable iff (rst)
    timer_restart_o |-> link_o);

  // R8
  restart_single_chk: assert property (@(posedge clk) disable iff (rst)
    timer_restart_o |=> !timer_restart_o);
endmodule

bind hsw_link_ctrl hsw_link_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .fault_drop_i(fault_drop_i),
  .link_o(link_o), .ready_o(ready_o), .accel_en_o(accel_en_o),
  .timer_restart_o(timer_restart_o)
);

// File: tb/hsw_link_ctrl_bench.sv
module hsw_link_ctrl_bench;
  localparam int IDLE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic sda_a = 1'b1, scl_a = 1'b1, sda_b = 1'b1, scl_b = 1'b1;
  logic fdrop = 1'b0, fbusy = 1'b0;
  logic link, ready, accel, restart;

  int n_cmp = 0, n_bad = 0, n_restart = 0;
  bit done = 1'b0;

  typedef struct {
    logic  l, r, a;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  hsw_link_ctrl #(.IDLE_CYC(IDLE)) u_hsw_link_ctrl (
    .clk(clk), .rst(rst), .en_i(en),
    .sda_in_i(sda_a), .scl_in_i(scl_a),
    .sda_out_i(sda_b), .scl_out_i(scl_b),
    .fault_drop_i(fdrop), .fault_busy_i(fbusy),
    .link_o(link), .ready_o(ready), .accel_en_o(accel),
    .timer_restart_o(restart)
  );

  always @(posedge clk) if (!rst && restart) n_restart++;

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (link !== e.l || ready !== e.r || accel !== e.a) begin
        n_bad++;
        $display("FAIL %s: link/ready/accel=%b%b%b expected %b%b%b",
                 e.tag, link, ready, accel, e.l, e.r, e.a);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_out(input logic l, input logic r, input logic a, input string tag);
    exp_t e;
    e.l = l; e.r = r; e.a = a; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_fault();
    fdrop = 1'b1;
    tick(1);
    fdrop = 1'b0;
  endtask

  initial begin
    int rc;
    tick(5);
    expect_out(0, 0, 0, "R1 during reset");
    tick(1);
    rst = 1'b0;
    tick(5);
    expect_out(0, 0, 0, "R1 lockout before idle time");
    tick(30);
    expect_out(1, 1, 1, "R2 join on both idle");
    tick(1);
    expect_out(1, 1, 1, "R6 ready follows join");

    fbusy = 1'b1;
    tick(2);
    expect_out(1, 1, 0, "R10 accel off during recovery");
    fbusy = 1'b0;
    tick(2);
    expect_out(1, 1, 1, "R10 accel back on");

    en = 1'b0;
    tick(2);
    expect_out(1, 1, 1, "R5 two edges after enable low");
    tick(1);
    expect_out(0, 0, 0, "R5 third edge after enable low");

    scl_a = 1'b0; sda_a = 1'b0;
    tick(5);
    en = 1'b1;
    tick(10);
    expect_out(0, 0, 0, "R4 enable high with busy side");
    scl_a = 1'b1;
    tick(3);
    sda_a = 1'b1;
    tick(6);
    expect_out(1, 1, 1, "R3 stop on input side, output idle");

    en = 1'b0;
    scl_a = 1'b0; sda_a = 1'b0; scl_b = 1'b0; sda_b = 1'b0;
    tick(5);
    en = 1'b1;
    tick(5);
    scl_a = 1'b1;
    tick(2);
    sda_a = 1'b1;
    tick(6);
    expect_out(0, 0, 0, "R4 stop while other side busy");
    tick(25);
    expect_out(0, 0, 0, "R4 one side idle, other busy");
    scl_b = 1'b1;
    tick(2);
    sda_b = 1'b1;
    tick(6);
    expect_out(1, 1, 1, "R3 stop on output side, input idle");

    scl_b = 1'b0;
    tick(3);
    pulse_fault();
    expect_out(0, 0, 0, "R7 fault disconnects next edge");
    tick(10);
    expect_out(0, 0, 0, "R7 stays apart while stuck");

    en = 1'b0;
    tick(5);
    rc = n_restart;
    en = 1'b1;
    tick(8);
    expect_out(1, 1, 1, "R8 forced join while stuck");
    chk_int("R8 one restart pulse", n_restart - rc, 1);

    pulse_fault();
    expect_out(0, 0, 0, "R7 second fault");
    rc = n_restart;
    scl_b = 1'b1;
    tick(30);
    expect_out(1, 1, 1, "R9 rejoin by idle rule");
    chk_int("R9 no restart pulse", n_restart - rc, 0);

    en = 1'b0;
    tick(5);
    scl_a = 1'b0; sda_a = 1'b0;
    tick(5);
    en = 1'b1;
    tick(5);
    scl_a = 1'b1;
    tick(3);
    en = 1'b0; sda_a = 1'b1;
    tick(10);
    expect_out(0, 0, 0, "R11 enable low beats stop");
    tick(30);
    expect_out(0, 0, 0, "R11 still apart with enable low");

    tick(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule